// File: doc/BRIEF.md
# Two-Channel Regulator Start-Up and Protection Sequencer

This block holds the digital sequencing and protection control for a two-channel multi-phase buck controller. Each channel waits until its enable, the controller supply-good flag and the power-stage-ready flag are all true. It then walks through a fixed reset period, a programmable delay and a programmable soft-start ramp, followed by a power-good delay. After that the channel reports power-good. Comparator results arrive already compared, as single-bit flags: over-voltage high and low, under-voltage, per-phase over-current, over-temperature and die thermal shutdown. A one-cycle switching tick paces the over-current count.

Faults are handled in one of two ways. Over-voltage is recoverable: the channel clamps the low-side switches until the flag clears, then resumes. Under-voltage, over-current and over-temperature put the channel into a hiccup: all switches are turned off for a multiple of the soft-start time that depends on the cause, and a fresh start-up follows. In the paired-rail (DDR) mode, channel 1 uses the delay of channel 0, and a hiccup in either channel drags the other one along. All times are counted in clock cycles.

Top module: `buck_seq_ctrl`

## Requirements
- R1: A channel leaves idle only while its enable, `vcc_ok` and `drv_ok` are all 1. Until soft-start begins, its PWM mode stays tristate. PWM mode codes are 2 bits per channel at bits [2c+1:2c]: 0 = tristate, 1 = switching, 2 = all low-side on, 3 = all off. After reset every output is 0.
- R2: After start-up is allowed, the channel spends RST_CYC cycles in reset and max(delay,1) cycles in delay. Then `ss_run` is high for max(ss,1) cycles, and `pgood` rises PGD_CYC cycles after `ss_run` falls.
- R3: One cycle after its enable goes low, a channel has `pgood` = 0 and tristate PWM.
- R4: Over-voltage-high is monitored from the first soft-start cycle onward. When it is high for OVH_DEB consecutive cycles, PWM mode becomes all low-side on.
- R5: Over-voltage-low is monitored only once `pgood` has been reached. When it is high for OVL_DEB consecutive cycles, `pgood` drops and PWM mode becomes all low-side on. It has no effect during soft-start or the power-good delay.
- R6: Over-voltage is recoverable. The cycle after both over-voltage flags are low, PWM mode returns to switching and `pgood` returns without a hiccup. Cause bit 0 marks over-voltage.
- R7: Under-voltage is monitored only after the power-good delay. When it is high for UV_DEB consecutive cycles, the channel enters hiccup (`hiccup` = 1, PWM all off) for 12×ss cycles and sets cause bit 1. It is ignored during soft-start.
- R8: Over-current enters hiccup only after every phase of the channel has been flagged on more than OC_CYC consecutive ticks. A tick with any phase clear restarts the count. The hiccup lasts 16×ss cycles and sets cause bit 2.
- R9: Over-temperature, from soft-start onward, enters hiccup on the next cycle for 8×ss cycles and sets cause bit 3. If several causes trip in the same cycle, over-current wins over under-voltage, which wins over over-temperature, and only the winner is latched.
- R10: While `tsd`, `vcc_ok` and at least one enable are all 1, every PWM output is tristate and `pgood` is 0. Once `tsd` clears, the channels start up again by themselves.
- R11: With `ddr_mode` = 1, channel 1 uses `dly0`, and a hiccup trip in either running channel puts both into hiccup in the same cycle with the same length. With `ddr_mode` = 0, the channels are independent.
- R12: Cause bits stay set through the hiccup and the restart. They clear on the cycle `pgood` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ok | input | 1 | Controller supply good |
| drv_ok | input | 1 | Power stages ready |
| en | input | 2 | Per-channel enable |
| ddr_mode | input | 1 | Paired-rail mode |
| tsd | input | 1 | Die over-temperature flag |
| dly0 | input | CNT_W | Channel 0 delay in cycles |
| dly1 | input | CNT_W | Channel 1 delay in cycles |
| ss_len | input | CNT_W | Soft-start length in cycles, shared |
| sw_tick | input | 1 | One-cycle switching-period tick |
| ovh | input | 2 | Over-voltage-high flag per channel |
| ovl | input | 2 | Over-voltage-low flag per channel |
| uv | input | 2 | Under-voltage flag per channel |
| oc | input | 2*NPH | Per-phase over-current, channel c at [c*NPH +: NPH] |
| ot | input | 2 | Over-temperature flag per channel |
| pgood | output | 2 | Power-good per channel |
| ss_run | output | 2 | Soft-start ramp enable |
| pwm_mode | output | 4 | PWM mode, 2 bits per channel |
| hiccup | output | 2 | Channel in hiccup off-time |
| fault_cause | output | 8 | Cause bits, 4 per channel at [4c+3:4c] |

## Verification
Two situations are hard to reach from the ports. The first is a trip of two causes in the same cycle. The bench builds up eight over-current ticks on all phases, then raises over-temperature together with the ninth tick. It checks that only the over-current cause latches and that the off-time is 16×ss. The second is the over-current count restart: one tick with a single phase clear between two runs of eight must prevent the hiccup. The start-up timing is swept over every combination of a small set of delay and soft-start values. The paired-rail joint hiccup is provoked from channel 1 and measured on channel 0.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    typedef enum logic [1:0] {
        PWM_TRI  = 2'd0,
        PWM_RUN  = 2'd1,
        PWM_LSON = 2'd2,
        PWM_OFF  = 2'd3
    } pwm_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RST  = 3'd1,
        ST_DLY  = 3'd2,
        ST_SOFT = 3'd3,
        ST_PGD  = 3'd4,
        ST_ON   = 3'd5,
        ST_HIC  = 3'd6
    } seq_state_e;

    localparam int CAUSE_N  = 4;
    localparam int CAUSE_OV = 0;
    localparam int CAUSE_UV = 1;
    localparam int CAUSE_OC = 2;
    localparam int CAUSE_OT = 3;

endpackage

// File: rtl/buck_seq_deb.sv
module buck_seq_deb #(
    parameter int LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic flag_i,
    output logic trip_o
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] cnt_d, cnt_q;
    logic         hit;

    assign hit    = arm_i && flag_i && (cnt_q == W'(LEN - 1));
    assign trip_o = hit;

    always_comb begin
        if (!(arm_i && flag_i)) begin
            cnt_d = '0;
        end else if (cnt_q >= W'(LEN - 1)) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DEB_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> $past(flag_i) || (LEN == 1)); // R4

endmodule

// File: rtl/buck_seq_chan.sv
module buck_seq_chan
    import buck_seq_pkg::*;
#(
    parameter int NPH     = 2,
    parameter int CNT_W   = 24,
    parameter int RST_CYC = 200000,
    parameter int PGD_CYC = 10000,
    parameter int OVH_DEB = 100,
    parameter int OVL_DEB = 100,
    parameter int UV_DEB  = 150,
    parameter int OC_CYC  = 8,
    localparam int HW     = CNT_W + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic               ddr_i,
    input  logic [CNT_W-1:0]   dly_i,
    input  logic [CNT_W-1:0]   ss_i,
    input  logic               tick_i,
    input  logic               ovh_i,
    input  logic               ovl_i,
    input  logic               uv_i,
    input  logic [NPH-1:0]     oc_i,
    input  logic               ot_i,
    input  logic               peer_trip_i,
    input  logic [HW-1:0]      peer_len_i,
    output logic               trip_o,
    output logic [HW-1:0]      trip_len_o,
    output logic               pgood_o,
    output logic               ss_run_o,
    output pwm_mode_e          pwm_o,
    output logic               hiccup_o,
    output logic [CAUSE_N-1:0] cause_o
);
    localparam int OCW = $clog2(OC_CYC + 2);

    typedef struct packed {
        seq_state_e           state;
        logic [HW-1:0]        cnt;
        logic [HW-1:0]        hic_len;
        logic [OCW-1:0]       oc_c;
        logic                 ov;
        logic [CAUSE_N-1:0]   cause;
        logic                 pgood;
    } chan_t;

    chan_t d, q;

    logic          mon_ss, mon_on, all_oc;
    logic          ovh_t, ovl_t, uv_t, oc_t, ot_t;
    logic [HW-1:0] cnt_inc, dly_x, ss_x, len8, len12, len16;

    assign mon_ss = go_i && (q.state inside {ST_SOFT, ST_PGD, ST_ON});
    assign mon_on = go_i && (q.state == ST_ON);
    assign all_oc = &oc_i;

    buck_seq_deb #(.LEN(OVH_DEB)) u_ovh (
        .clk(clk), .rst_n(rst_n), .arm_i(mon_ss), .flag_i(ovh_i), .trip_o(ovh_t));
    buck_seq_deb #(.LEN(OVL_DEB)) u_ovl (
        .clk(clk), .rst_n(rst_n), .arm_i(mon_on), .flag_i(ovl_i), .trip_o(ovl_t));
    buck_seq_deb #(.LEN(UV_DEB)) u_uv (
        .clk(clk), .rst_n(rst_n), .arm_i(mon_on), .flag_i(uv_i), .trip_o(uv_t));

    assign oc_t = mon_ss && tick_i && all_oc && (q.oc_c == OCW'(OC_CYC));
    assign ot_t = mon_ss && ot_i;

    assign dly_x = {{(HW - CNT_W){1'b0}}, dly_i};
    assign ss_x  = {{(HW - CNT_W){1'b0}}, ss_i};
    assign len8  = ss_x << 3;
    assign len12 = (ss_x << 3) + (ss_x << 2);
    assign len16 = ss_x << 4;

    assign trip_o     = oc_t || uv_t || ot_t;
    assign trip_len_o = oc_t ? len16 : (uv_t ? len12 : len8);
    assign cnt_inc    = q.cnt + 1'b1;

    always_comb begin
        d = q;

        if (!mon_ss) begin
            d.oc_c = '0;
        end else if (tick_i) begin
            if (!all_oc)                          d.oc_c = '0;
            else if (q.oc_c != OCW'(OC_CYC))      d.oc_c = q.oc_c + 1'b1;
        end

        if (ovh_t || ovl_t) begin
            d.ov = 1'b1;
            d.cause[CAUSE_OV] = 1'b1;
        end else if (q.ov && !ovl_i && !ovh_i) begin
            d.ov = 1'b0;
        end

        case (q.state)
            ST_IDLE: begin
                d.state = ST_RST;
                d.cnt   = '0;
            end
            ST_RST: begin
                if (cnt_inc >= HW'(RST_CYC)) begin d.state = ST_DLY; d.cnt = '0; end
                else d.cnt = cnt_inc;
            end
            ST_DLY: begin
                if (cnt_inc >= dly_x) begin d.state = ST_SOFT; d.cnt = '0; end
                else d.cnt = cnt_inc;
            end
            ST_SOFT: begin
                if (cnt_inc >= ss_x) begin d.state = ST_PGD; d.cnt = '0; end
                else d.cnt = cnt_inc;
            end
            ST_PGD: begin
                if (cnt_inc >= HW'(PGD_CYC)) begin d.state = ST_ON; d.cnt = '0; end
                else d.cnt = cnt_inc;
            end
            ST_ON: d.cnt = '0;
            ST_HIC: begin
                if (cnt_inc >= q.hic_len) begin d.state = ST_RST; d.cnt = '0; end
                else d.cnt = cnt_inc;
            end
            default: d.state = ST_IDLE;
        endcase

        if (trip_o) begin
            d.state   = ST_HIC;
            d.cnt     = '0;
            d.hic_len = trip_len_o;
            d.ov      = 1'b0;
            d.oc_c    = '0;
            if (oc_t)      d.cause[CAUSE_OC] = 1'b1;
            else if (uv_t) d.cause[CAUSE_UV] = 1'b1;
            else           d.cause[CAUSE_OT] = 1'b1;
        end else if (ddr_i && peer_trip_i &&
                     (q.state inside {ST_RST, ST_DLY, ST_SOFT, ST_PGD, ST_ON})) begin
            d.state   = ST_HIC;
            d.cnt     = '0;
            d.hic_len = peer_len_i;
            d.ov      = 1'b0;
            d.oc_c    = '0;
        end

        if (!go_i) begin
            d.state = ST_IDLE;
            d.cnt   = '0;
            d.ov    = 1'b0;
            d.oc_c  = '0;
        end

        d.pgood = (d.state == ST_ON) && !d.ov;
        if (d.pgood && !q.pgood) d.cause = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.state)
            ST_SOFT, ST_PGD, ST_ON: pwm_o = q.ov ? PWM_LSON : PWM_RUN;
            ST_HIC:                 pwm_o = PWM_OFF;
            default:                pwm_o = PWM_TRI;
        endcase
    end

    assign pgood_o  = q.pgood;
    assign ss_run_o = (q.state == ST_SOFT);
    assign hiccup_o = (q.state == ST_HIC);
    assign cause_o  = q.cause;

    AST_PG_DROPS_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> !pgood_o); // R3
    AST_RAMP_AFTER_TRI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_run_o) |-> $past(pwm_o) == PWM_TRI); // R1
    AST_PG_MEANS_SWITCHING: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_o |-> pwm_o == PWM_RUN); // R6
    AST_HIC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hiccup_o) |-> $past(uv_i) || $past(ot_i) || $past(all_oc) || $past(peer_trip_i)); // R7

endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
    import buck_seq_pkg::*;
#(
    parameter int NPH     = 2,
    parameter int CNT_W   = 24,
    parameter int RST_CYC = 200000,
    parameter int PGD_CYC = 10000,
    parameter int OVH_DEB = 100,
    parameter int OVL_DEB = 100,
    parameter int UV_DEB  = 150,
    parameter int OC_CYC  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vcc_ok,
    input  logic               drv_ok,
    input  logic [1:0]         en,
    input  logic               ddr_mode,
    input  logic               tsd,
    input  logic [CNT_W-1:0]   dly0,
    input  logic [CNT_W-1:0]   dly1,
    input  logic [CNT_W-1:0]   ss_len,
    input  logic               sw_tick,
    input  logic [1:0]         ovh,
    input  logic [1:0]         ovl,
    input  logic [1:0]         uv,
    input  logic [2*NPH-1:0]   oc,
    input  logic [1:0]         ot,
    output logic [1:0]         pgood,
    output logic [1:0]         ss_run,
    output logic [3:0]         pwm_mode,
    output logic [1:0]         hiccup,
    output logic [7:0]         fault_cause
);
    localparam int NCH = 2;
    localparam int HW  = CNT_W + 5;

    logic              tsd_act;
    logic [NCH-1:0]    go, trip;
    logic [HW-1:0]     trip_len [NCH];
    pwm_mode_e         ch_pwm   [NCH];

    assign tsd_act = tsd && vcc_ok && (|en);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int PEER = NCH - 1 - c;
        logic [CNT_W-1:0] dly_sel;

        assign go[c]   = en[c] && vcc_ok && drv_ok && !tsd_act;
        assign dly_sel = (c == 0 || ddr_mode) ? dly0 : dly1;

        buck_seq_chan #(
            .NPH(NPH), .CNT_W(CNT_W), .RST_CYC(RST_CYC), .PGD_CYC(PGD_CYC),
            .OVH_DEB(OVH_DEB), .OVL_DEB(OVL_DEB), .UV_DEB(UV_DEB), .OC_CYC(OC_CYC)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .go_i        (go[c]),
            .ddr_i       (ddr_mode),
            .dly_i       (dly_sel),
            .ss_i        (ss_len),
            .tick_i      (sw_tick),
            .ovh_i       (ovh[c]),
            .ovl_i       (ovl[c]),
            .uv_i        (uv[c]),
            .oc_i        (oc[c*NPH +: NPH]),
            .ot_i        (ot[c]),
            .peer_trip_i (trip[PEER]),
            .peer_len_i  (trip_len[PEER]),
            .trip_o      (trip[c]),
            .trip_len_o  (trip_len[c]),
            .pgood_o     (pgood[c]),
            .ss_run_o    (ss_run[c]),
            .pwm_o       (ch_pwm[c]),
            .hiccup_o    (hiccup[c]),
            .cause_o     (fault_cause[4*c +: 4])
        );

        assign pwm_mode[2*c +: 2] = tsd_act ? PWM_TRI : ch_pwm[c];
    end

    AST_TSD_KILLS_PGOOD: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_act |=> pgood == 2'b00); // R10
    AST_DDR_JOINT_HICCUP: assert property (@(posedge clk) disable iff (!rst_n)
        (ddr_mode && $past(ddr_mode) && $rose(hiccup[0]) && $past(pgood[1]) && go[1])
        |-> hiccup[1]); // R11

endmodule

// File: tb/tb_buck_seq_ctrl.sv
module tb_buck_seq_ctrl;
    localparam int NPH = 2, CW = 8, RST = 12, PGD = 8, OVHD = 3, OVLD = 3, UVD = 4, OCC = 8;

    logic clk = 0, rst_n = 0, vcc_ok = 0, drv_ok = 0, ddr_mode = 0, tsd = 0, sw_tick = 0;
    logic [1:0] en = 0, ovh = 0, ovl = 0, uv = 0, ot = 0;
    logic [2*NPH-1:0] oc = 0;
    logic [CW-1:0] dly0 = 0, dly1 = 0, ss_len = 1;
    logic [1:0] pgood, ss_run, hiccup;
    logic [3:0] pwm_mode;
    logic [7:0] fault_cause;
    int n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    buck_seq_ctrl #(.NPH(NPH), .CNT_W(CW), .RST_CYC(RST), .PGD_CYC(PGD), .OVH_DEB(OVHD),
        .OVL_DEB(OVLD), .UV_DEB(UVD), .OC_CYC(OCC)) dut (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .drv_ok(drv_ok), .en(en),
        .ddr_mode(ddr_mode), .tsd(tsd), .dly0(dly0), .dly1(dly1), .ss_len(ss_len),
        .sw_tick(sw_tick), .ovh(ovh), .ovl(ovl), .uv(uv), .oc(oc), .ot(ot),
        .pgood(pgood), .ss_run(ss_run), .pwm_mode(pwm_mode), .hiccup(hiccup),
        .fault_cause(fault_cause));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pw(input int ch);
        return int'(pwm_mode[2*ch +: 2]);
    endfunction

    task automatic wait_pg(input int ch);
        int k = 0;
        while (!pgood[ch] && k < 3000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_ss(input int ch);
        int k = 0;
        while (!ss_run[ch] && k < 3000) begin @(negedge clk); k++; end
    endtask

    task automatic up(input int ch);
        @(negedge clk); en[ch] = 1'b1;
        wait_pg(ch);
    endtask

    task automatic down(input int ch);
        @(negedge clk); en[ch] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic meas_hic(input int ch, output int h);
        h = 0;
        while (hiccup[ch] && h < 3000) begin h++; @(negedge clk); end
    endtask

    task automatic tick;
        @(negedge clk); sw_tick = 1'b1;
        @(negedge clk); sw_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired R1 actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n, m, p, h;
        bit tri_bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(pgood == 0 && pwm_mode == 0 && hiccup == 0 && fault_cause == 0 && ss_run == 0,
            "R1 reset state", int'(pwm_mode), 0);

        // R1: start gated by drv_ok and vcc_ok
        en = 2'b01; vcc_ok = 1; drv_ok = 0;
        repeat (30) @(negedge clk);
        chk(pw(0) == 0 && ss_run[0] == 0, "R1 held without drv_ok", pw(0), 0);
        vcc_ok = 0; drv_ok = 1;
        repeat (30) @(negedge clk);
        chk(pw(0) == 0 && ss_run[0] == 0, "R1 held without vcc_ok", pw(0), 0);
        en = 0; vcc_ok = 1;
        repeat (2) @(negedge clk);

        // R2 sweep of delay and soft-start
        for (int dl = 0; dl < 4; dl++) begin
            for (int s = 1; s < 4; s++) begin
                dly0 = CW'(dl); ss_len = CW'(s);
                @(negedge clk); en[0] = 1'b1;
                n = 0; tri_bad = 0;
                do begin
                    @(negedge clk); n++;
                    if (!ss_run[0] && pw(0) != 0) tri_bad = 1;
                end while (!ss_run[0] && n < 1000);
                chk(n == RST + ((dl < 1) ? 1 : dl) + 1, "R2 start to ramp", n,
                    RST + ((dl < 1) ? 1 : dl) + 1);
                chk(!tri_bad, "R1 tristate before ramp", int'(tri_bad), 0);
                m = 0;
                while (ss_run[0] && m < 1000) begin m++; @(negedge clk); end
                chk(m == s, "R2 ramp length", m, s);
                p = 0;
                while (!pgood[0] && p < 1000) begin p++; @(negedge clk); end
                chk(p == PGD, "R2 pgood delay", p, PGD);
                en[0] = 1'b0;
                @(negedge clk);
                chk(pgood[0] == 0 && pw(0) == 0, "R3 pgood drop on disable", int'(pgood[0]), 0);
                @(negedge clk);
            end
        end

        // R4: over-voltage-high during soft-start
        dly0 = 1; ss_len = 10;
        @(negedge clk); en[0] = 1'b1;
        wait_ss(0);
        ovh[0] = 1; ovl[0] = 1;
        repeat (OVHD - 1) @(negedge clk);
        chk(pw(0) == 1, "R4 no clamp before debounce", pw(0), 1);
        @(negedge clk);
        chk(pw(0) == 2 && ss_run[0] == 1, "R4 low-side clamp in ramp", pw(0), 2);
        ovh[0] = 0; ovl[0] = 0;
        @(negedge clk);
        chk(pw(0) == 1 && hiccup[0] == 0, "R6 recover after ovh", pw(0), 1);
        wait_pg(0);

        // R5/R6: over-voltage-low at on
        ovl[0] = 1;
        repeat (OVLD - 1) @(negedge clk);
        chk(pgood[0] == 1, "R5 pgood held before debounce", int'(pgood[0]), 1);
        @(negedge clk);
        chk(pgood[0] == 0 && pw(0) == 2 && fault_cause[0] == 1, "R5 ovl trip", pw(0), 2);
        repeat (20) @(negedge clk);
        chk(hiccup[0] == 0 && pw(0) == 2, "R6 no hiccup while ov", int'(hiccup[0]), 0);
        ovl[0] = 0;
        @(negedge clk);
        chk(pgood[0] == 1 && pw(0) == 1 && fault_cause[3:0] == 0, "R6 ov recovery", int'(pgood[0]), 1);

        // R5: ovl masked in power-good delay
        down(0);
        @(negedge clk); en[0] = 1'b1;
        wait_ss(0);
        while (ss_run[0]) @(negedge clk);
        ovl[0] = 1; tri_bad = 0;
        repeat (5) begin @(negedge clk); if (pw(0) != 1) tri_bad = 1; end
        ovl[0] = 0;
        chk(!tri_bad, "R5 ovl ignored before pgood", int'(tri_bad), 0);
        wait_pg(0);
        chk(pgood[0] == 1, "R5 pgood after masked ovl", int'(pgood[0]), 1);

        // R7: uv masked in ramp, then trip
        down(0);
        @(negedge clk); en[0] = 1'b1;
        wait_ss(0);
        uv[0] = 1;
        repeat (6) @(negedge clk);
        chk(hiccup[0] == 0, "R7 uv ignored in ramp", int'(hiccup[0]), 0);
        uv[0] = 0;
        wait_pg(0);
        uv[0] = 1;
        repeat (UVD - 1) @(negedge clk);
        chk(hiccup[0] == 0, "R7 no hiccup before debounce", int'(hiccup[0]), 0);
        @(negedge clk);
        chk(hiccup[0] == 1 && pw(0) == 3 && fault_cause[3:0] == 4'b0010, "R7 uv hiccup",
            int'(fault_cause[3:0]), 2);
        uv[0] = 0;
        meas_hic(0, h);
        chk(h == 12 * 10, "R7 uv off-time", h, 120);
        wait_ss(0);
        chk(fault_cause[1] == 1, "R12 cause held through restart", int'(fault_cause[1]), 1);
        wait_pg(0);
        @(negedge clk);
        chk(fault_cause[3:0] == 0, "R12 cause cleared at pgood", int'(fault_cause[3:0]), 0);

        // R8: over-current counting
        oc = 4'b0001;
        repeat (12) tick();
        chk(hiccup[0] == 0, "R8 single phase no trip", int'(hiccup[0]), 0);
        oc = 4'b0011;
        repeat (8) tick();
        oc = 4'b0001;
        tick();
        oc = 4'b0011;
        repeat (8) tick();
        chk(hiccup[0] == 0, "R8 count restarted", int'(hiccup[0]), 0);
        tick();
        chk(hiccup[0] == 1 && fault_cause[3:0] == 4'b0100, "R8 oc hiccup", int'(fault_cause[3:0]), 4);
        oc = 0;
        meas_hic(0, h);
        chk(h == 16 * 10, "R8 oc off-time", h, 160);
        wait_pg(0);

        // R9: priority oc over ot in same cycle
        oc = 4'b0011;
        repeat (8) tick();
        @(negedge clk); sw_tick = 1; ot[0] = 1;
        @(negedge clk); sw_tick = 0; ot[0] = 0; oc = 0;
        chk(hiccup[0] == 1 && fault_cause[3:0] == 4'b0100, "R9 oc wins over ot",
            int'(fault_cause[3:0]), 4);
        meas_hic(0, h);
        chk(h == 160, "R9 winner off-time", h, 160);
        wait_pg(0);

        // R9: ot alone
        @(negedge clk); ot[0] = 1;
        @(negedge clk); ot[0] = 0;
        chk(hiccup[0] == 1 && fault_cause[3:0] == 4'b1000, "R9 ot hiccup", int'(fault_cause[3:0]), 8);
        meas_hic(0, h);
        chk(h == 8 * 10, "R9 ot off-time", h, 80);
        wait_pg(0);

        // R10: thermal shutdown
        @(negedge clk); tsd = 1;
        @(negedge clk);
        chk(pw(0) == 0 && pgood[0] == 0, "R10 tsd tristate", pw(0), 0);
        repeat (20) @(negedge clk);
        chk(pw(0) == 0 && ss_run[0] == 0, "R10 held in tsd", pw(0), 0);
        tsd = 0;
        wait_pg(0);
        chk(pgood[0] == 1, "R10 auto recovery", int'(pgood[0]), 1);

        // R11: paired mode
        down(0);
        ddr_mode = 1; dly0 = 2; dly1 = 7; ss_len = 3;
        @(negedge clk); en = 2'b11;
        wait_ss(0);
        chk(ss_run[1] == 1, "R11 shared delay", int'(ss_run[1]), 1);
        wait_pg(0); wait_pg(1);
        uv[1] = 1;
        repeat (UVD) @(negedge clk);
        uv[1] = 0;
        chk(hiccup == 2'b11 && fault_cause[3:0] == 0 && fault_cause[7:4] == 4'b0010,
            "R11 joint hiccup", int'(hiccup), 3);
        meas_hic(0, h);
        chk(h == 36, "R11 joint off-time", h, 36);
        wait_pg(0); wait_pg(1);

        // R11: independent mode
        @(negedge clk); en = 0; ddr_mode = 0;
        repeat (2) @(negedge clk);
        en = 2'b11;
        wait_ss(0);
        chk(ss_run[1] == 0, "R11 own delay", int'(ss_run[1]), 0);
        wait_pg(0); wait_pg(1);
        uv[1] = 1;
        repeat (UVD) @(negedge clk);
        uv[1] = 0;
        chk(hiccup == 2'b10 && pgood[0] == 1, "R11 independent hiccup", int'(hiccup), 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule